// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog countdown timer programmed through a small byte-addressed register port. Software chooses a 10-bit initial tick count, releases or holds the counter with a halt control bit, and keeps the system alive by writing the reload register before the count runs out. The counter steps down once for each pulse on a tick-enable input. Each tick nominally represents 0.6 s and is produced outside the block.

Expiry is handled in two stages. When the counter runs out for the first time, the block sets a sticky first-timeout status, emits a one-cycle interrupt pulse and starts counting again from the initial value. If the counter runs out again while that status is still set, the block records a second-timeout status and raises a system reset request. A no-reboot control bit can block that request. When it does, the second timeout is still recorded, together with a boot status. The reset request stays asserted until the block itself is reset. Software restarts the full two-stage sequence by clearing the first-timeout status and reloading the counter.

Top module: `wdog_dual_stage`

## Requirements
- R1: After reset the halt bit (control offset 0x08, bit 11) is 1 and the no-reboot bit (control bit 0) is 1. The initial count is 0x004 and the counter holds 0x004. All status bits are 0, and neither the interrupt pulse nor the reset request is asserted.
- R2: Any write to offset 0x00, whatever the data, loads the counter with the programmed initial count on the next cycle. Such a write takes priority over a tick in the same cycle, and that tick causes no expiry.
- R3: While the halt bit is 0, each tick_en cycle lowers a non-zero count by one. While the halt bit is 1, or when tick_en is low, the count holds.
- R4: A write to offset 0x12 always stores bits [15:10]. Bits [9:0] replace the initial count only if their value is 4 or more; values 0 to 3 leave the previous count in place.
- R5: Control offset 0x08 stores the halt bit (bit 11) and the no-reboot bit (bit 0). Both read back as written, and every other bit reads 0.
- R6: A tick while the counter runs at zero reloads the initial count. If the first-timeout status (offset 0x04, bit 3) is clear, that status is set and irq_pulse is high for exactly one cycle.
- R7: If the first-timeout status is already set at an expiry, the second-timeout status (offset 0x06, bit 1) is set and no interrupt pulse is given. With the no-reboot bit at 0, sys_rst_req is raised.
- R8: With the no-reboot bit at 1, a second-stage expiry does not raise sys_rst_req. It sets the second-timeout status and the boot status (offset 0x06, bit 2).
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new expiry sets the first-timeout status in the same cycle as a clearing write, the bit ends up set.
- R10: Once raised, sys_rst_req stays high until rst_n is asserted.
- R11: Offset 0x00 reads the remaining count in bits [9:0], with the upper bits 0. Unmapped offsets read 0.
- R12: After the first-timeout status has been cleared, the next expiry is a first-stage expiry again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count step enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Byte offset of the combinational read |
| rd_data | output | 16 | Read data |
| irq_pulse | output | 1 | One-cycle pulse on a first-stage expiry |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
Two collisions matter in this block. The first is a tick that expires the counter in the same cycle as a write-one-to-clear of the first-timeout status: the bench drives both on one clock edge and expects the status to remain set with an interrupt pulse. The second is a tick at count zero in the same cycle as a reload write: the bench expects the counter to hold the initial count and no expiry to be recorded. A behavioural model, stepped on every clock with the same stimulus, judges both collisions and also a long stretch of pseudo-random writes and ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    parameter int unsigned DATA_W  = 16;
    parameter int unsigned ADDR_W  = 8;
    parameter int unsigned COUNT_W = 10;

    // Register offsets seen by software
    localparam logic [7:0] OFS_RELOAD = 8'h00;
    localparam logic [7:0] OFS_STAT1  = 8'h04;
    localparam logic [7:0] OFS_STAT2  = 8'h06;
    localparam logic [7:0] OFS_CTRL   = 8'h08;
    localparam logic [7:0] OFS_INIT   = 8'h12;

    // Bit positions inside the registers
    localparam int unsigned BIT_FIRST    = 3;
    localparam int unsigned BIT_SECOND   = 1;
    localparam int unsigned BIT_BOOT     = 2;
    localparam int unsigned BIT_HALT     = 11;
    localparam int unsigned BIT_NOREBOOT = 0;

    // Smallest accepted initial count and the value taken at reset
    localparam int unsigned MIN_COUNT  = 4;
    localparam int unsigned RESET_INIT = 4;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned CW = COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] init_val,
    output logic [DW-CW-1:0] init_hi,
    output logic          halt,
    output logic          no_reboot
);
    localparam int unsigned HW = DW - CW;

    typedef struct packed {
        logic [CW-1:0] init;
        logic [HW-1:0] hi;
        logic          halt;
        logic          nrb;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic init_wr, ctrl_wr, count_ok;

    always_comb begin
        init_wr  = wr_en && (wr_addr == AW'(OFS_INIT));
        ctrl_wr  = wr_en && (wr_addr == AW'(OFS_CTRL));
        count_ok = wr_data[CW-1:0] >= CW'(MIN_COUNT);
        cfg_d    = cfg_q;
        if (init_wr) begin
            cfg_d.hi = wr_data[DW-1:CW];
            if (count_ok) begin
                cfg_d.init = wr_data[CW-1:0];
            end
        end
        if (ctrl_wr) begin
            cfg_d.halt = wr_data[BIT_HALT];
            cfg_d.nrb  = wr_data[BIT_NOREBOOT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.init <= CW'(RESET_INIT);
            cfg_q.hi   <= '0;
            cfg_q.halt <= 1'b1;
            cfg_q.nrb  <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign init_val  = cfg_q.init;
    assign init_hi   = cfg_q.hi;
    assign halt      = cfg_q.halt;
    assign no_reboot = cfg_q.nrb;

    // R4: a count below the minimum leaves the stored count untouched
    assert_small_init_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (init_wr && !count_ok) |=> $stable(init_val));

    // R5: a control write is reflected in the halt bit on the next cycle
    assert_halt_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (halt == $past(wr_data[BIT_HALT])));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned CW = COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          halt,
    input  logic          reload_wr,
    input  logic [CW-1:0] init_val,
    output logic [CW-1:0] count,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic step, at_zero;

    always_comb begin
        step    = tick_en && !halt;
        at_zero = (st_q.cnt == '0);
        expire  = step && at_zero && !reload_wr;
        st_d    = st_q;
        if (reload_wr) begin
            st_d.cnt = init_val;
        end else if (step) begin
            st_d.cnt = at_zero ? init_val : (st_q.cnt - CW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= CW'(RESET_INIT);
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // R2: a reload write loads the initial count
    assert_reload_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> (count == $past(init_val)));

    // R3: a running tick on a non-zero count steps down by one
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !halt && !reload_wr && count != '0) |=> (count == $past(count) - CW'(1)));

    // R3: halted counter holds unless reloaded
    assert_halt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload_wr) |=> $stable(count));
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic no_reboot,
    input  logic clr_first,
    input  logic clr_second,
    input  logic clr_boot,
    output logic first_sts,
    output logic second_sts,
    output logic boot_sts,
    output logic irq,
    output logic rst_req
);
    typedef struct packed {
        logic first;
        logic second;
        logic boot;
        logic irq;
        logic rst;
    } stage_t;

    stage_t sg_d, sg_q;
    logic stage_one, stage_two;

    always_comb begin
        stage_one    = expire && !sg_q.first;
        stage_two    = expire && sg_q.first;
        sg_d.irq     = stage_one;
        sg_d.first   = (sg_q.first  && !clr_first)  || stage_one;
        sg_d.second  = (sg_q.second && !clr_second) || stage_two;
        sg_d.boot    = (sg_q.boot   && !clr_boot)   || (stage_two && no_reboot);
        sg_d.rst     = sg_q.rst || (stage_two && !no_reboot);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sg_q <= '0;
        end else begin
            sg_q <= sg_d;
        end
    end

    assign first_sts  = sg_q.first;
    assign second_sts = sg_q.second;
    assign boot_sts   = sg_q.boot;
    assign irq        = sg_q.irq;
    assign rst_req    = sg_q.rst;

    // R6: the interrupt is a single-cycle pulse
    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: an expiry with the first status set records the second status
    assert_second_recorded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && first_sts) |=> (second_sts && !irq));

    // R8: no-reboot blocks a new reset request
    assert_noreboot_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (no_reboot && !rst_req) |=> !rst_req);

    // R10: the reset request is sticky
    assert_rst_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R9: an expiry sets the first status even against a clearing write
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !first_sts) |=> first_sts);
endmodule

// File: rtl/wdog_dual_stage.sv
module wdog_dual_stage
    import wdog_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned CW = COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq_pulse,
    output logic          sys_rst_req
);
    logic [CW-1:0]    init_val;
    logic [DW-CW-1:0] init_hi;
    logic [CW-1:0]    count;
    logic halt, no_reboot, expire;
    logic reload_wr, clr_first, clr_second, clr_boot;
    logic first_sts, second_sts, boot_sts;

    always_comb begin
        reload_wr  = wr_en && (wr_addr == AW'(OFS_RELOAD));
        clr_first  = wr_en && (wr_addr == AW'(OFS_STAT1)) && wr_data[BIT_FIRST];
        clr_second = wr_en && (wr_addr == AW'(OFS_STAT2)) && wr_data[BIT_SECOND];
        clr_boot   = wr_en && (wr_addr == AW'(OFS_STAT2)) && wr_data[BIT_BOOT];
    end

    wdog_cfg #(.DW(DW), .AW(AW), .CW(CW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .init_val  (init_val),
        .init_hi   (init_hi),
        .halt      (halt),
        .no_reboot (no_reboot)
    );

    wdog_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .halt      (halt),
        .reload_wr (reload_wr),
        .init_val  (init_val),
        .count     (count),
        .expire    (expire)
    );

    wdog_stage u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .no_reboot  (no_reboot),
        .clr_first  (clr_first),
        .clr_second (clr_second),
        .clr_boot   (clr_boot),
        .first_sts  (first_sts),
        .second_sts (second_sts),
        .boot_sts   (boot_sts),
        .irq        (irq_pulse),
        .rst_req    (sys_rst_req)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(OFS_RELOAD): rd_data[CW-1:0] = count;
            AW'(OFS_STAT1):  rd_data[BIT_FIRST] = first_sts;
            AW'(OFS_STAT2): begin
                rd_data[BIT_SECOND] = second_sts;
                rd_data[BIT_BOOT]   = boot_sts;
            end
            AW'(OFS_CTRL): begin
                rd_data[BIT_HALT]     = halt;
                rd_data[BIT_NOREBOOT] = no_reboot;
            end
            AW'(OFS_INIT):   rd_data = {init_hi, init_val};
            default:         rd_data = '0;
        endcase
    end

    // R1: the interrupt pulse only follows a counter expiry
    assert_irq_after_expiry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(expire));
endmodule

// File: tb/sim_wdog_dual_stage.sv
module sim_wdog_dual_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [15:0] wr_data = 16'h0000;
    logic [7:0]  rd_addr = 8'h00;
    logic [15:0] rd_data;
    logic        irq_pulse, sys_rst_req;

    int n_checks = 0;
    int n_errors = 0;
    int rot = 0;
    int seed = 32'h1234_5678;

    // reference model state
    int m_cnt, m_init, m_hi, m_halt, m_nr, m_s1, m_s2, m_boot, m_irq, m_rst;

    always #5 clk = ~clk;

    wdog_dual_stage u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_pulse(irq_pulse), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 4; m_init = 4; m_hi = 0; m_halt = 1; m_nr = 1;
        m_s1 = 0; m_s2 = 0; m_boot = 0; m_irq = 0; m_rst = 0;
    endtask

    function automatic int mread(input int a);
        case (a)
            8'h00: return m_cnt;
            8'h04: return m_s1 << 3;
            8'h06: return (m_s2 << 1) | (m_boot << 2);
            8'h08: return (m_halt << 11) | m_nr;
            8'h12: return (m_hi << 10) | m_init;
            default: return 0;
        endcase
    endfunction

    task automatic model_step(input int we, input int wa, input int wd, input int tk);
        int rl, ex, sec, wc;
        rl  = we && (wa == 8'h00);
        ex  = tk && !m_halt && (m_cnt == 0) && !rl;
        sec = ex && m_s1;
        if (rl) m_cnt = m_init;
        else if (tk && !m_halt) m_cnt = (m_cnt == 0) ? m_init : m_cnt - 1;
        m_irq  = ex && !m_s1;
        m_rst  = m_rst || (sec && !m_nr);
        m_boot = (m_boot && !(we && wa == 8'h06 && wd[2])) || (sec && m_nr);
        m_s2   = (m_s2 && !(we && wa == 8'h06 && wd[1])) || sec;
        m_s1   = (m_s1 && !(we && wa == 8'h04 && wd[3])) || (ex && !m_s1);
        if (we && wa == 8'h08) begin m_halt = (wd >> 11) & 1; m_nr = wd & 1; end
        if (we && wa == 8'h12) begin
            m_hi = (wd >> 10) & 8'h3f;
            wc = wd & 10'h3ff;
            if (wc >= 4) m_init = wc;
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input int we, input int wa, input int wd, input int tk);
        int addrs[6] = '{8'h00, 8'h04, 8'h06, 8'h08, 8'h12, 8'h20};
        wr_en = 1'(we); wr_addr = 8'(wa); wr_data = 16'(wd); tick_en = 1'(tk);
        rd_addr = 8'(addrs[rot % 6]);
        rot++;
        @(posedge clk);
        model_step(we, wa, wd, tk);
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        #1;
        chk("R6 irq_pulse vs model", int'(irq_pulse), m_irq);
        chk("R10 sys_rst_req vs model", int'(sys_rst_req), m_rst);
        chk("R11 rd_data vs model", int'(rd_data), mread(int'(rd_addr)));
    endtask

    task automatic expect_reg(input string tag, input int a, input int exp);
        rd_addr = 8'(a);
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        expect_reg("R1 count", 8'h00, 16'h0004);
        expect_reg("R1 first status", 8'h04, 16'h0000);
        expect_reg("R1 second/boot status", 8'h06, 16'h0000);
        expect_reg("R1 control", 8'h08, 16'h0801);
        expect_reg("R1 init", 8'h12, 16'h0004);
        chk("R1 irq low", int'(irq_pulse), 0);
        chk("R1 rst low", int'(sys_rst_req), 0);
        cyc(0, 0, 0, 1);
        expect_reg("R3 halted after reset holds", 8'h00, 16'h0004);

        // R4 initial count writes
        cyc(1, 8'h12, 16'hFC05, 0);
        expect_reg("R4 init stored", 8'h12, 16'hFC05);
        cyc(1, 8'h12, 16'h0003, 0);
        expect_reg("R4 small count ignored", 8'h12, 16'h0005);
        expect_reg("R11 unmapped reads 0", 8'h20, 16'h0000);

        // R5 control
        cyc(1, 8'h08, 16'hF7FF, 0);
        expect_reg("R5 control readback", 8'h08, 16'h0001);

        // R2 reload, R3 stepping
        cyc(1, 8'h00, 16'hABCD, 0);
        expect_reg("R2 reload value", 8'h00, 16'h0005);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1);
        expect_reg("R3 stepped", 8'h00, 16'h0002);
        cyc(1, 8'h08, 16'h0801, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        expect_reg("R3 halted holds", 8'h00, 16'h0002);
        cyc(1, 8'h08, 16'h0001, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        expect_reg("R3 reached zero", 8'h00, 16'h0000);

        // R6 first expiry
        cyc(0, 0, 0, 1);
        chk("R6 irq on first expiry", int'(irq_pulse), 1);
        expect_reg("R6 count reloaded", 8'h00, 16'h0005);
        expect_reg("R6 first status", 8'h04, 16'h0008);
        cyc(0, 0, 0, 0);
        chk("R6 irq one cycle", int'(irq_pulse), 0);

        // R7/R8 second expiry with no-reboot set
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1);
        chk("R8 no reset with no-reboot", int'(sys_rst_req), 0);
        chk("R7 no irq on second stage", int'(irq_pulse), 0);
        expect_reg("R8 second and boot status", 8'h06, 16'h0006);

        // R9 write-one-to-clear
        cyc(1, 8'h04, 16'h0000, 0);
        expect_reg("R9 write 0 keeps status", 8'h04, 16'h0008);
        cyc(1, 8'h04, 16'h0008, 0);
        expect_reg("R9 write 1 clears", 8'h04, 16'h0000);
        cyc(1, 8'h06, 16'h0006, 0);
        expect_reg("R9 second/boot cleared", 8'h06, 16'h0000);

        // R12 sequence restarts
        cyc(1, 8'h00, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1);
        chk("R12 first stage again irq", int'(irq_pulse), 1);
        expect_reg("R12 second status still clear", 8'h06, 16'h0000);

        // R9 collision: clear and first expiry in the same cycle
        cyc(1, 8'h04, 16'h0008, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);
        cyc(1, 8'h04, 16'h0008, 1);
        chk("R9 set wins irq", int'(irq_pulse), 1);
        expect_reg("R9 set wins status", 8'h04, 16'h0008);

        // R2 collision: reload write with a tick at zero
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);
        cyc(1, 8'h00, 0, 1);
        chk("R2 no expiry on reload", int'(irq_pulse), 0);
        expect_reg("R2 reload beats tick", 8'h00, 16'h0005);
        expect_reg("R2 no second stage", 8'h06, 16'h0000);

        // pseudo-random traffic, no-reboot kept set
        for (int i = 0; i < 3000; i++) begin
            int r, we, wa, wd;
            int offs[6] = '{8'h00, 8'h04, 8'h06, 8'h08, 8'h12, 8'h30};
            seed = seed * 1103515245 + 12345;
            r  = (seed >>> 8) & 32'h00FF_FFFF;
            we = ((r & 15) == 0) ? 1 : 0;
            wa = offs[(r >> 4) % 6];
            wd = (r >> 7) & 16'hFFFF;
            if (wa == 8'h08) wd = (wd & 16'h0800) | 1;
            if (wa == 8'h12) wd = (wd & 16'hFC00) | 4 | (wd & 3);
            cyc(we, wa, wd, ((r >> 3) & 1));
        end

        // R7/R10 real reset request
        cyc(1, 8'h08, 16'h0000, 0);
        cyc(1, 8'h04, 16'h0008, 0);
        cyc(1, 8'h06, 16'h0006, 0);
        cyc(1, 8'h12, 16'h0004, 0);
        cyc(1, 8'h00, 0, 0);
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1);
        chk("R7 reset requested", int'(sys_rst_req), 1);
        expect_reg("R7 second status", 8'h06, 16'h0002);
        cyc(1, 8'h06, 16'h0006, 0);
        cyc(1, 8'h04, 16'h0008, 0);
        cyc(0, 0, 0, 0);
        chk("R10 reset request held", int'(sys_rst_req), 1);
        do_reset();
        #1;
        chk("R10 reset request cleared by reset", int'(sys_rst_req), 0);
        expect_reg("R1 control after second reset", 8'h08, 16'h0801);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule